// File: doc/BRIEF.md
# Mailbox-Driven Serial Link Command Engine

This block runs single transactions on a bit-serial master link on behalf of a host. The host loads a command bit string, left-aligned, into two 32-bit words. It then writes a control word holding an opcode, the number of command bits to send and the number of response data bits to expect, and pulses a doorbell. The engine clocks the command out on a clock/data pin pair, most significant bit first. It then keeps the link clock running until the target answers with a start bit, and captures the target's tag, its data and its 4-bit check code. A single status byte tracks progress, and the host polls it until it leaves the busy value.

After reset the control word reads all ones. On the first clock the engine replaces it with zero, so a host that polls the control word can tell when the engine is ready. If no start bit arrives within a programmable number of link clock periods, the engine reports a master timeout. A break opcode sends a fixed run of ones and expects no answer.

Top module: `serial_link_mailbox`

## Requirements
- R1: While reset is asserted the control word (address 0) reads 0xFFFFFFFF. On the first clock edge after reset is released it becomes 0x00000000. The status byte reads 0x00 after reset, and the pins rest with link_clk=1 and link_dout=0.
- R2: Register map, by word address. Address 0 is the control word: opcode in bits 7:0, command length in bits 15:8, response length in bits 23:16. Address 1 holds status in bits 7:0, the received tag in bits 15:8 and the received check code in bits 23:16. Address 2 holds command bits 63:32, which are sent first. Address 3 holds command bits 31:0. Address 4 holds the response data, right-aligned. Address 5 holds the timeout limit, which resets to TMO_INIT.
- R3: When the doorbell is accepted with opcode 0x01, the top clen bits of {addr2,addr3} are sent MSB first. Each bit is driven on link_dout for one cycle with link_clk=0, then one cycle with link_clk=1. The first low cycle follows the edge that samples the doorbell.
- R4: After the last command bit, link_clk keeps alternating low/high and link_din is sampled at the end of each high cycle. A 1 is the start bit. It is followed by a 2-bit tag, then rlen data bits, then 4 check bits, each field MSB first. On the last bit the engine stores the tag, the data (right-aligned, upper bits zero) and the check code, sets status 0x02, and returns the pins to rest.
- R5: If the number of consecutive zero samples while waiting for the start bit reaches the timeout limit, status becomes 0x83 and the stored tag, data and check code are left unchanged.
- R6: Opcode 0x02 sends BRK_LEN bit periods with link_dout=1, captures nothing, and then sets status 0x02.
- R7: A doorbell whose opcode is neither 0x01 nor 0x02, or whose opcode is 0x01 with clen 0, clen above 64 or rlen above 32, sets status 0x80 and causes no link activity.
- R8: A doorbell that arrives while status is 0x01 is ignored: the transfer in progress continues unchanged on the pins.
- R9: A host write to address 1 while status is not 0x01 sets status to 0x00 and keeps the stored tag and check code. While status is 0x01 such a write is ignored.
- R10: Status reads 0x01 from the edge that accepts a doorbell until the transaction ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Host register write strobe |
| wr_addr | input | 3 | Host write word address |
| wr_data | input | 32 | Host write data |
| rd_addr | input | 3 | Host read word address |
| rd_data | output | 32 | Host read data (combinational) |
| doorbell | input | 1 | One-cycle start request |
| link_din | input | 1 | Serial data from target |
| link_clk | output | 1 | Serial link clock |
| link_dout | output | 1 | Serial data to target |

## Verification
The bench builds the engine with BRK_LEN of 8 and TMO_INIT of 20. It lowers the timeout limit to 5 through the register, so break runs and both sides of the timeout boundary take only a few dozen cycles. A start bit after 4 zero samples still completes, while one after 5 zeros times out. The default 64-bit command capacity is kept, so both the full-length command and the one-bit command are exercised. Response lengths of 0, 8 and 32 bits cover the right-alignment edges.

// File: rtl/sl_mbox_pkg.sv
package sl_mbox_pkg;
    // opcodes carried in control word bits 7:0
    localparam logic [7:0] OP_SEND  = 8'h01;
    localparam logic [7:0] OP_BREAK = 8'h02;

    // status byte codes
    localparam logic [7:0] ST_STOPPED = 8'h00;
    localparam logic [7:0] ST_BUSY    = 8'h01;
    localparam logic [7:0] ST_DONE    = 8'h02;
    localparam logic [7:0] ST_BAD_CMD = 8'h80;
    localparam logic [7:0] ST_TIMEOUT = 8'h83;

    // word addresses
    localparam logic [2:0] A_CTRL  = 3'd0;
    localparam logic [2:0] A_STAT  = 3'd1;
    localparam logic [2:0] A_HI    = 3'd2;
    localparam logic [2:0] A_LO    = 3'd3;
    localparam logic [2:0] A_RESP  = 3'd4;
    localparam logic [2:0] A_LIMIT = 3'd5;

    typedef enum logic [1:0] {PH_IDLE, PH_SEND, PH_WAIT, PH_RECV} phy_state_e;
endpackage

// File: rtl/sl_mbox_regs.sv
module sl_mbox_regs
    import sl_mbox_pkg::*;
#(
    parameter int WORD_W   = 32,
    parameter int RSP_W    = 32,
    parameter int TAG_W    = 2,
    parameter int CRC_W    = 4,
    parameter int TMO_W    = 16,
    parameter int TMO_INIT = 1000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [2:0]          wr_addr,
    input  logic [WORD_W-1:0]   wr_data,
    input  logic [2:0]          rd_addr,
    output logic [WORD_W-1:0]   rd_data,
    input  logic                doorbell,
    input  logic                done,
    input  logic [7:0]          done_code,
    input  logic                done_cap,
    input  logic [TAG_W-1:0]    cap_tag,
    input  logic [RSP_W-1:0]    cap_data,
    input  logic [CRC_W-1:0]    cap_crc,
    output logic                start,
    output logic                start_brk,
    output logic [7:0]          clen,
    output logic [7:0]          rlen,
    output logic [2*WORD_W-1:0] cmd_bits,
    output logic [TMO_W-1:0]    tmo_limit
);
    localparam int CMD_W = 2 * WORD_W;

    typedef struct packed {
        logic [WORD_W-1:0] ctrl;
        logic [WORD_W-1:0] hi;
        logic [WORD_W-1:0] lo;
        logic [RSP_W-1:0]  resp;
        logic [7:0]        tag;
        logic [7:0]        crc;
        logic [7:0]        status;
        logic [TMO_W-1:0]  limit;
        logic              ready;
    } regs_t;

    regs_t q, d;
    logic [7:0] opc;
    logic       len_ok;
    logic       accept;

    always_comb begin
        opc    = q.ctrl[7:0];
        clen   = q.ctrl[15:8];
        rlen   = q.ctrl[23:16];
        len_ok = (clen != 8'd0) && (clen <= 8'(CMD_W)) && (rlen <= 8'(RSP_W));
        accept = doorbell && q.ready && (q.status != ST_BUSY);
        start  = accept && (((opc == OP_SEND) && len_ok) || (opc == OP_BREAK));
        start_brk = (opc == OP_BREAK);
        cmd_bits  = {q.hi, q.lo};
        tmo_limit = q.limit;

        d = q;
        if (!q.ready) begin
            d.ready = 1'b1;
            d.ctrl  = '0;
        end
        if (wr_en) begin
            case (wr_addr)
                A_CTRL:  d.ctrl = wr_data;
                A_HI:    d.hi = wr_data;
                A_LO:    d.lo = wr_data;
                A_LIMIT: d.limit = TMO_W'(wr_data);
                A_STAT:  if (q.status != ST_BUSY) d.status = ST_STOPPED;
                default: ;
            endcase
        end
        if (start)
            d.status = ST_BUSY;
        else if (accept)
            d.status = ST_BAD_CMD;
        if (done) begin
            d.status = done_code;
            if (done_cap) begin
                d.tag  = 8'(cap_tag);
                d.crc  = 8'(cap_crc);
                d.resp = cap_data;
            end
        end

        case (rd_addr)
            A_CTRL:  rd_data = q.ctrl;
            A_STAT:  rd_data = WORD_W'({q.crc, q.tag, q.status});
            A_HI:    rd_data = q.hi;
            A_LO:    rd_data = q.lo;
            A_RESP:  rd_data = WORD_W'(q.resp);
            A_LIMIT: rd_data = WORD_W'(q.limit);
            default: rd_data = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.ctrl  <= '1;
            q.limit <= TMO_W'(TMO_INIT);
        end else begin
            q <= d;
        end
    end

    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (q.status == ST_BUSY)); // R10
    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        (q.status == ST_BUSY && doorbell && !done) |=> (q.status == ST_BUSY)); // R8
endmodule

// File: rtl/sl_mbox_phy.sv
module sl_mbox_phy
    import sl_mbox_pkg::*;
#(
    parameter int CMD_W   = 64,
    parameter int RSP_W   = 32,
    parameter int TAG_W   = 2,
    parameter int CRC_W   = 4,
    parameter int TMO_W   = 16,
    parameter int BRK_LEN = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             start_brk,
    input  logic [7:0]       clen,
    input  logic [7:0]       rlen,
    input  logic [CMD_W-1:0] cmd_bits,
    input  logic [TMO_W-1:0] tmo_limit,
    input  logic             link_din,
    output logic             link_clk,
    output logic             link_dout,
    output logic             done,
    output logic [7:0]       done_code,
    output logic             done_cap,
    output logic [TAG_W-1:0] cap_tag,
    output logic [RSP_W-1:0] cap_data,
    output logic [CRC_W-1:0] cap_crc
);
    localparam int FRAME_W = TAG_W + RSP_W + CRC_W;
    localparam int MAX_A   = (CMD_W > FRAME_W) ? CMD_W : FRAME_W;
    localparam int MAX_N   = (MAX_A > BRK_LEN) ? MAX_A : BRK_LEN;
    localparam int CNT_W   = $clog2(MAX_N + 1);

    typedef struct packed {
        phy_state_e        st;
        logic              ph;
        logic [CNT_W-1:0]  cnt;
        logic [CMD_W-1:0]  tx;
        logic [FRAME_W-1:0] rx;
        logic [7:0]        rlen;
        logic [TMO_W-1:0]  tmo;
        logic              brk;
        logic              sclk;
        logic              sdo;
        logic              done;
        logic [7:0]        code;
        logic              cap;
        logic [TAG_W-1:0]  tag;
        logic [RSP_W-1:0]  data;
        logic [CRC_W-1:0]  crc;
    } phy_t;

    phy_t q, d;
    logic [FRAME_W-1:0] rx_next;
    logic [TMO_W:0]     tmo_inc;

    always_comb begin
        rx_next = {q.rx[FRAME_W-2:0], link_din};
        tmo_inc = {1'b0, q.tmo} + 1'b1;
        d = q;
        d.done = 1'b0;
        d.cap  = 1'b0;
        case (q.st)
            PH_IDLE: if (start) begin
                d.st   = PH_SEND;
                d.ph   = 1'b0;
                d.brk  = start_brk;
                d.rlen = rlen;
                d.cnt  = start_brk ? CNT_W'(BRK_LEN) : CNT_W'(clen);
                d.tx   = start_brk ? '1 : cmd_bits;
                d.sclk = 1'b0;
                d.sdo  = start_brk | cmd_bits[CMD_W-1];
            end
            PH_SEND: if (!q.ph) begin
                d.ph   = 1'b1;
                d.sclk = 1'b1;
            end else begin
                d.tx  = q.tx << 1;
                d.cnt = q.cnt - 1'b1;
                d.ph  = 1'b0;
                if (q.cnt == CNT_W'(1)) begin
                    d.sdo = 1'b0;
                    if (q.brk) begin
                        d.st   = PH_IDLE;
                        d.sclk = 1'b1;
                        d.done = 1'b1;
                        d.code = ST_DONE;
                    end else begin
                        d.st   = PH_WAIT;
                        d.sclk = 1'b0;
                        d.tmo  = '0;
                    end
                end else begin
                    d.sclk = 1'b0;
                    d.sdo  = q.tx[CMD_W-2];
                end
            end
            PH_WAIT: if (!q.ph) begin
                d.ph   = 1'b1;
                d.sclk = 1'b1;
            end else begin
                d.ph = 1'b0;
                if (link_din) begin
                    d.st   = PH_RECV;
                    d.cnt  = CNT_W'(q.rlen) + CNT_W'(TAG_W + CRC_W);
                    d.rx   = '0;
                    d.sclk = 1'b0;
                end else if (tmo_inc >= {1'b0, tmo_limit}) begin
                    d.st   = PH_IDLE;
                    d.done = 1'b1;
                    d.code = ST_TIMEOUT;
                end else begin
                    d.tmo  = tmo_inc[TMO_W-1:0];
                    d.sclk = 1'b0;
                end
            end
            PH_RECV: if (!q.ph) begin
                d.ph   = 1'b1;
                d.sclk = 1'b1;
            end else begin
                d.rx  = rx_next;
                d.cnt = q.cnt - 1'b1;
                d.ph  = 1'b0;
                if (q.cnt == CNT_W'(1)) begin
                    d.st   = PH_IDLE;
                    d.done = 1'b1;
                    d.cap  = 1'b1;
                    d.code = ST_DONE;
                    d.crc  = rx_next[CRC_W-1:0];
                    d.data = RSP_W'(rx_next >> CRC_W) & ~({RSP_W{1'b1}} << q.rlen);
                    d.tag  = TAG_W'(rx_next >> (CRC_W + int'(q.rlen)));
                end else begin
                    d.sclk = 1'b0;
                end
            end
            default: d.st = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.sclk <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign link_clk  = q.sclk;
    assign link_dout = q.sdo;
    assign done      = q.done;
    assign done_code = q.code;
    assign done_cap  = q.cap;
    assign cap_tag   = q.tag;
    assign cap_data  = q.data;
    assign cap_crc   = q.crc;

    AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == PH_SEND && q.sclk && !$past(q.sclk)) |-> (q.sdo == $past(q.sdo))); // R3
    AST_TMO_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == PH_WAIT) |-> ((q.tmo < tmo_limit) || (q.tmo == '0))); // R5
    AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (q.st == PH_IDLE)); // R8
    AST_REST_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (link_clk && !link_dout)); // R4
endmodule

// File: rtl/serial_link_mailbox.sv
module serial_link_mailbox #(
    parameter int WORD_W   = 32,
    parameter int RSP_W    = 32,
    parameter int TAG_W    = 2,
    parameter int CRC_W    = 4,
    parameter int TMO_W    = 16,
    parameter int TMO_INIT = 1000,
    parameter int BRK_LEN  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [2:0]        rd_addr,
    output logic [WORD_W-1:0] rd_data,
    input  logic              doorbell,
    input  logic              link_din,
    output logic              link_clk,
    output logic              link_dout
);
    localparam int CMD_W = 2 * WORD_W;

    logic             start, start_brk, done, done_cap;
    logic [7:0]       clen, rlen, done_code;
    logic [CMD_W-1:0] cmd_bits;
    logic [TMO_W-1:0] tmo_limit;
    logic [TAG_W-1:0] cap_tag;
    logic [RSP_W-1:0] cap_data;
    logic [CRC_W-1:0] cap_crc;

    sl_mbox_regs #(
        .WORD_W(WORD_W), .RSP_W(RSP_W), .TAG_W(TAG_W), .CRC_W(CRC_W),
        .TMO_W(TMO_W), .TMO_INIT(TMO_INIT)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .doorbell(doorbell), .done(done), .done_code(done_code),
        .done_cap(done_cap), .cap_tag(cap_tag), .cap_data(cap_data),
        .cap_crc(cap_crc), .start(start), .start_brk(start_brk),
        .clen(clen), .rlen(rlen), .cmd_bits(cmd_bits), .tmo_limit(tmo_limit)
    );

    sl_mbox_phy #(
        .CMD_W(CMD_W), .RSP_W(RSP_W), .TAG_W(TAG_W), .CRC_W(CRC_W),
        .TMO_W(TMO_W), .BRK_LEN(BRK_LEN)
    ) u_phy (
        .clk(clk), .rst_n(rst_n), .start(start), .start_brk(start_brk),
        .clen(clen), .rlen(rlen), .cmd_bits(cmd_bits), .tmo_limit(tmo_limit),
        .link_din(link_din), .link_clk(link_clk), .link_dout(link_dout),
        .done(done), .done_code(done_code), .done_cap(done_cap),
        .cap_tag(cap_tag), .cap_data(cap_data), .cap_crc(cap_crc)
    );
endmodule

// File: tb/serial_link_mailbox_test.sv
module serial_link_mailbox_test;
    localparam int BRK = 8;
    localparam int TMO0 = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [2:0] wr_addr = 3'd0;
    logic [31:0] wr_data = 32'd0;
    logic [2:0] rd_addr = 3'd0;
    logic [31:0] rd_data;
    logic doorbell = 1'b0;
    logic link_din = 1'b0;
    logic link_clk, link_dout;

    int checks = 0;
    int fails = 0;
    bit go = 1'b0;
    bit chk_on = 1'b0;
    logic [1:0] expq[$];
    logic respq[$];

    serial_link_mailbox #(.TMO_INIT(TMO0), .BRK_LEN(BRK)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .doorbell(doorbell), .link_din(link_din), .link_clk(link_clk),
        .link_dout(link_dout)
    );

    always #5 clk = ~clk;

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", r, act, exp);
        end
    endtask

    // pin reference model: compares every cycle, drives target replies
    always @(negedge clk) begin
        if (chk_on) begin
            if (go) begin
                if (expq.size() > 0) begin
                    logic [1:0] p;
                    p = expq.pop_front();
                    chk("R3 pins {clk,dout}", {30'd0, link_clk, link_dout}, {30'd0, p});
                end
                if (link_clk == 1'b0)
                    link_din = (expq.size() == 0 && respq.size() > 0) ? respq.pop_front() : 1'b0;
            end else begin
                chk("R7 rest pins", {30'd0, link_clk, link_dout}, 32'd2);
                link_din = 1'b0;
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        rd_addr = a;
        #1 v = rd_data;
    endtask

    task automatic ring(input bit track);
        @(negedge clk);
        doorbell = 1'b1;
        @(posedge clk);
        #1 doorbell = 1'b0;
        if (track) go = 1'b1;
    endtask

    task automatic setup(input logic [63:0] bits, input int clen, input int rlen,
                         input int delay, input bit answer, input logic [1:0] tg,
                         input logic [31:0] dat, input logic [3:0] cr);
        expq.delete();
        respq.delete();
        for (int i = 0; i < clen; i++) begin
            expq.push_back({1'b0, bits[63-i]});
            expq.push_back({1'b1, bits[63-i]});
        end
        expq.push_back(2'b00);
        if (answer) begin
            for (int i = 0; i < delay; i++) respq.push_back(1'b0);
            respq.push_back(1'b1);
            respq.push_back(tg[1]);
            respq.push_back(tg[0]);
            for (int i = rlen - 1; i >= 0; i--) respq.push_back(dat[i]);
            for (int i = 3; i >= 0; i--) respq.push_back(cr[i]);
        end
        wr(3'd2, bits[63:32]);
        wr(3'd3, bits[31:0]);
        wr(3'd0, {8'h00, 8'(rlen), 8'(clen), 8'h01});
    endtask

    task automatic wait_end(output logic [7:0] st);
        logic [31:0] v;
        st = 8'h01;
        for (int i = 0; i < 3000 && st == 8'h01; i++) begin
            rd(3'd1, v);
            st = v[7:0];
        end
        go = 1'b0;
        chk("R3 every expected pin cycle seen", expq.size(), 0);
        respq.delete();
    endtask

    task automatic result(input string r, input logic [7:0] st, input logic [1:0] tg,
                          input logic [31:0] dat, input logic [3:0] cr);
        logic [31:0] v;
        chk({r, " status"}, {24'd0, st}, 32'h02);
        rd(3'd4, v);
        chk({r, " data"}, v, dat);
        rd(3'd1, v);
        chk({r, " tag"}, {24'd0, v[15:8]}, {30'd0, tg});
        chk({r, " crc"}, {24'd0, v[23:16]}, {28'd0, cr});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [7:0] st;
        // R1 reset state
        repeat (2) @(negedge clk);
        rd_addr = 3'd0;
        #1 chk("R1 ctrl all ones in reset", rd_data, 32'hFFFFFFFF);
        chk("R1 rest pins in reset", {30'd0, link_clk, link_dout}, 32'd2);
        @(negedge clk);
        rst_n = 1'b1;
        rd(3'd0, v);
        chk("R1 ctrl cleared after init", v, 32'h0);
        rd(3'd1, v);
        chk("R1 status word after reset", v, 32'h0);
        rd(3'd5, v);
        chk("R2 limit reset value", v, TMO0);
        chk_on = 1'b1;

        // R3/R4: 8-bit command, 32-bit answer after 2 idle samples
        setup(64'hA5C3_0000_0000_0000, 8, 32, 2, 1'b1, 2'b01, 32'hDEADBEEF, 4'hA);
        ring(1'b1);
        rd(3'd1, v);
        chk("R10 busy after accept", {24'd0, v[7:0]}, 32'h01);
        wait_end(st);
        result("R4 clen8 rlen32", st, 2'b01, 32'hDEADBEEF, 4'hA);

        // R3/R4: full 64-bit command, 8-bit answer, immediate start bit
        setup(64'h8123_4567_89AB_CDEF, 64, 8, 0, 1'b1, 2'b11, 32'h0000005A, 4'h5);
        ring(1'b1);
        wait_end(st);
        result("R4 clen64 rlen8", st, 2'b11, 32'h0000005A, 4'h5);

        // R4: one-bit command, zero-length data
        setup(64'h8000_0000_0000_0000, 1, 0, 1, 1'b1, 2'b10, 32'h0, 4'hC);
        ring(1'b1);
        wait_end(st);
        result("R4 clen1 rlen0", st, 2'b10, 32'h0, 4'hC);

        // R9: clear keeps tag and crc
        wr(3'd1, 32'h0);
        rd(3'd1, v);
        chk("R9 status cleared", {24'd0, v[7:0]}, 32'h0);
        chk("R9 tag/crc kept", {16'd0, v[23:8]}, 32'h0C02);

        // R5: timeout boundary with limit 5
        wr(3'd5, 32'd5);
        setup(64'h4000_0000_0000_0000, 4, 16, 4, 1'b1, 2'b01, 32'h0000BEEF, 4'h3);
        ring(1'b1);
        wait_end(st);
        result("R5 four zeros then start", st, 2'b01, 32'h0000BEEF, 4'h3);
        setup(64'h4000_0000_0000_0000, 4, 16, 5, 1'b1, 2'b10, 32'h00001234, 4'h9);
        ring(1'b1);
        wait_end(st);
        chk("R5 five zeros time out", {24'd0, st}, 32'h83);
        rd(3'd4, v);
        chk("R5 data unchanged on timeout", v, 32'h0000BEEF);
        rd(3'd1, v);
        chk("R5 tag/crc unchanged on timeout", {16'd0, v[23:8]}, 32'h0301);

        // R6: break
        expq.delete();
        respq.delete();
        for (int i = 0; i < BRK; i++) begin
            expq.push_back(2'b01);
            expq.push_back(2'b11);
        end
        expq.push_back(2'b10);
        wr(3'd0, 32'h0000_0002);
        ring(1'b1);
        wait_end(st);
        chk("R6 break status", {24'd0, st}, 32'h02);
        rd(3'd4, v);
        chk("R6 break captures nothing", v, 32'h0000BEEF);

        // R7: invalid doorbells, pins checked at rest every cycle
        wr(3'd0, 32'h0020_0800);
        ring(1'b0);
        rd(3'd1, v);
        chk("R7 opcode 0x00", {24'd0, v[7:0]}, 32'h80);
        wr(3'd0, 32'h0020_0001);
        ring(1'b0);
        rd(3'd1, v);
        chk("R7 clen 0", {24'd0, v[7:0]}, 32'h80);
        wr(3'd0, 32'h0020_4101);
        ring(1'b0);
        rd(3'd1, v);
        chk("R7 clen 65", {24'd0, v[7:0]}, 32'h80);
        wr(3'd0, 32'h0021_0801);
        ring(1'b0);
        rd(3'd1, v);
        chk("R7 rlen 33", {24'd0, v[7:0]}, 32'h80);
        wr(3'd0, 32'h0000_00FF);
        ring(1'b0);
        rd(3'd1, v);
        chk("R7 opcode 0xFF", {24'd0, v[7:0]}, 32'h80);

        // R8/R9: doorbell and clear while busy are ignored
        setup(64'hF0F0_1234_5678_0F0F, 64, 12, 1, 1'b1, 2'b01, 32'h00000ABC, 4'h6);
        ring(1'b1);
        repeat (10) @(negedge clk);
        doorbell = 1'b1;
        @(negedge clk);
        doorbell = 1'b0;
        wr(3'd1, 32'h0);
        rd(3'd1, v);
        chk("R8 R9 still busy", {24'd0, v[7:0]}, 32'h01);
        wait_end(st);
        result("R8 transfer unaffected", st, 2'b01, 32'h00000ABC, 4'h6);

        repeat (4) @(negedge clk);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule